// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 SDRAM from power-on to a state where normal commands may be issued. After the synchronous system reset is released, it walks through a fixed timeline. First it holds the memory reset low. Then it holds clock-enable low. Then it pads with NOOPs. Then it programs the mode registers in the order MR2, MR3, MR1, MR0, and finishes with a long ZQ calibration. When the timeline is over, it raises a done flag so that the downstream controller can take over the command bus.

Every interval is a cycle-count parameter. At a 200 MHz clock the defaults give 40,000 cycles of reset, 100,000 cycles of clock-enable low, and settle times of tMRD = 4, tMOD = 12, tXPR = 34, tDLLK = 512 and tZQinit = 512. The four mode-register values are also parameters. The command outputs are decoded directly from the registered step, so each command appears on the bus for exactly one cycle.

Top module: `ddr3_init_seq`

## Requirements
- R1: After the first clock edge with `rst_n` high, `mem_reset_n` stays low for exactly `RST_HOLD_CYC` cycles, counting the cycle that follows the last reset edge. It then goes high and stays high.
- R2: `mem_cke` is low whenever `mem_reset_n` is low. It stays low for a further `CKE_HOLD_CYC` cycles after `mem_reset_n` rises, then goes high and stays high.
- R3: `mem_odt` is low in every cycle.
- R4: In every cycle that issues no command, the bus carries a NOOP: `{cs_n,ras_n,cas_n,we_n}` = 0111, with `mem_ba` = 0 and `mem_addr` = 0.
- R5: After `mem_cke` rises, the sequencer issues NOOPs for exactly `T_XPR + T_DLLK + T_ZQINIT` cycles before the first mode-register load.
- R6: A mode-register load lasts one cycle. It is encoded as `{cs_n,ras_n,cas_n,we_n}` = 0000, with `mem_ba` equal to the register number and `mem_addr` equal to that register's parameter value.
- R7: The loads come in the order MR2, MR3, MR1, MR0. They are followed by `T_MRD`, `T_MRD`, `T_MOD` and `T_MOD` NOOP cycles respectively.
- R8: On the MR0 load, address bit 8 (DLL reset) is high even when `MR0_VAL` has it clear. All other bits are taken from `MR0_VAL`.
- R9: After the MR0 wait, the sequencer issues one ZQ long calibration. It is encoded as `{cs_n,ras_n,cas_n,we_n}` = 0110, with `mem_addr` bit 10 high and all other address bits low, and `mem_ba` = 0. It is followed by `T_ZQINIT` NOOP cycles.
- R10: `init_done` is low until the ZQ wait ends. It then rises and stays high, with NOOP on the bus and `mem_cke`/`mem_reset_n` high.
- R11: Pulling `rst_n` low at any point, including mid-sequence, restarts the whole timeline from the reset-hold phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock (200 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_reset_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Row/column address |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds the sequencer with short intervals: a 20-cycle reset hold, a 30-cycle CKE hold, tXPR/tDLLK/tZQinit of 3/5/6, tMRD of 4 and tMOD of 7. A whole timeline therefore fits in under a hundred cycles, and the bench can run it twice: once cut short by a mid-sequence reset, and once to completion. Because tMRD and tMOD differ, a swapped wait shows up as a misplaced command. The MR0 value is given with bit 8 clear, which exposes a missing DLL-reset force. Distinct mode-register values and bank numbers make any reordering of the loads visible.

// File: rtl/ddr3_init_pkg.sv
// Package: shared types for the DDR3 initialization sequencer.
// Assumes: the step order below is the order of the timeline; the
// sequencer advances by incrementing the step value.
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        ST_RST_HOLD = 4'd0,
        ST_CKE_HOLD = 4'd1,
        ST_PAD      = 4'd2,
        ST_LOAD_MR2 = 4'd3,
        ST_WAIT_MR2 = 4'd4,
        ST_LOAD_MR3 = 4'd5,
        ST_WAIT_MR3 = 4'd6,
        ST_LOAD_MR1 = 4'd7,
        ST_WAIT_MR1 = 4'd8,
        ST_LOAD_MR0 = 4'd9,
        ST_WAIT_MR0 = 4'd10,
        ST_ZQ_CAL   = 4'd11,
        ST_WAIT_ZQ  = 4'd12,
        ST_READY    = 4'd13
    } init_step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_NOOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam mem_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam mem_cmd_t CMD_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/ddr3_init_timer.sv
// Module: phase timer. Counts cycles spent in the current step and flags
// the last cycle of it.
// Assumes: phase_len >= 1 whenever hold is low; the counter restarts
// when the step advances (last_cycle high and hold low).
module ddr3_init_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] phase_len,
    output logic             last_cycle
);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final cycle of the current step.
    assign last_cycle = !hold && (cnt_q == phase_len - CNT_W'(1));

    // Count cycles within a step; clear on reset and at each step change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold || last_cycle)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R7: the counter never runs past the length of the step it times.
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (cnt_q < phase_len));

endmodule

// File: rtl/ddr3_init_step_decode.sv
// Module: step decoder. Maps the current step to the pin levels, the
// command, the bank/address and the step length in cycles.
// Assumes: ADDR_W > 10 so that A10 and A8 exist; all lengths >= 1.
module ddr3_init_step_decode
    import ddr3_init_pkg::*;
#(
    parameter int          ADDR_W       = 14,
    parameter int          BA_W         = 3,
    parameter int          CNT_W        = 17,
    parameter int          RST_HOLD_CYC = 40000,
    parameter int          CKE_HOLD_CYC = 100000,
    parameter int          PAD_CYC      = 1058,
    parameter int          T_MRD        = 4,
    parameter int          T_MOD        = 12,
    parameter int          T_ZQINIT     = 512,
    parameter logic [ADDR_W-1:0] MR0_VAL = '0,
    parameter logic [ADDR_W-1:0] MR1_VAL = '0,
    parameter logic [ADDR_W-1:0] MR2_VAL = '0,
    parameter logic [ADDR_W-1:0] MR3_VAL = '0
) (
    input  init_step_e        step,
    output mem_cmd_t          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              reset_n,
    output logic              cke,
    output logic              ready,
    output logic [CNT_W-1:0]  len
);

    localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] ZQ_LONG_BIT = ADDR_W'(1) << 10;

    // Decode pins, command and length for the current step.
    always_comb begin
        cmd     = CMD_NOOP;
        ba      = '0;
        addr    = '0;
        reset_n = 1'b1;
        cke     = 1'b1;
        ready   = 1'b0;
        len     = CNT_W'(1);
        unique case (step)
            ST_RST_HOLD: begin reset_n = 1'b0; cke = 1'b0; len = CNT_W'(RST_HOLD_CYC); end
            ST_CKE_HOLD: begin cke = 1'b0; len = CNT_W'(CKE_HOLD_CYC); end
            ST_PAD:      len = CNT_W'(PAD_CYC);
            ST_LOAD_MR2: begin cmd = CMD_MRS; ba = BA_W'(2); addr = MR2_VAL; end
            ST_WAIT_MR2: len = CNT_W'(T_MRD);
            ST_LOAD_MR3: begin cmd = CMD_MRS; ba = BA_W'(3); addr = MR3_VAL; end
            ST_WAIT_MR3: len = CNT_W'(T_MRD);
            ST_LOAD_MR1: begin cmd = CMD_MRS; ba = BA_W'(1); addr = MR1_VAL; end
            ST_WAIT_MR1: len = CNT_W'(T_MOD);
            ST_LOAD_MR0: begin cmd = CMD_MRS; ba = BA_W'(0); addr = MR0_VAL | DLL_RST_BIT; end
            ST_WAIT_MR0: len = CNT_W'(T_MOD);
            ST_ZQ_CAL:   begin cmd = CMD_ZQCL; addr = ZQ_LONG_BIT; end
            ST_WAIT_ZQ:  len = CNT_W'(T_ZQINIT);
            ST_READY:    ready = 1'b1;
            default:     begin reset_n = 1'b0; cke = 1'b0; end
        endcase
    end

endmodule

// File: rtl/ddr3_init_seq.sv
// Module: DDR3 power-up initialization sequencer (top).
// Walks the fixed timeline: reset hold, CKE hold, NOOP padding,
// MR2/MR3/MR1/MR0 loads with settle waits, ZQ long calibration, done.
// Assumes: synchronous active-low rst_n; every interval parameter >= 1;
// ADDR_W > 10. Outputs are decoded from the registered step only.
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int BA_W         = 3,
    parameter int RST_HOLD_CYC = 40000,
    parameter int CKE_HOLD_CYC = 100000,
    parameter int T_XPR        = 34,
    parameter int T_DLLK       = 512,
    parameter int T_ZQINIT     = 512,
    parameter int T_MRD        = 4,
    parameter int T_MOD        = 12,
    parameter logic [ADDR_W-1:0] MR0_VAL = ADDR_W'(14'h0520),
    parameter logic [ADDR_W-1:0] MR1_VAL = ADDR_W'(14'h0044),
    parameter logic [ADDR_W-1:0] MR2_VAL = ADDR_W'(14'h0008),
    parameter logic [ADDR_W-1:0] MR3_VAL = ADDR_W'(14'h0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_reset_n,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);

    localparam int PAD_CYC  = T_XPR + T_DLLK + T_ZQINIT;
    localparam int MAX_A    = (RST_HOLD_CYC > CKE_HOLD_CYC) ? RST_HOLD_CYC : CKE_HOLD_CYC;
    localparam int MAX_B    = (PAD_CYC > T_MOD) ? PAD_CYC : T_MOD;
    localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    init_step_e       step_q;
    mem_cmd_t         cmd;
    logic [CNT_W-1:0] step_len;
    logic             step_last;
    logic             ready;

    ddr3_init_step_decode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .RST_HOLD_CYC(RST_HOLD_CYC), .CKE_HOLD_CYC(CKE_HOLD_CYC),
        .PAD_CYC(PAD_CYC), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT),
        .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL)
    ) decode_i (
        .step    (step_q),
        .cmd     (cmd),
        .ba      (mem_ba),
        .addr    (mem_addr),
        .reset_n (mem_reset_n),
        .cke     (mem_cke),
        .ready   (ready),
        .len     (step_len)
    );

    ddr3_init_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (ready),
        .phase_len  (step_len),
        .last_cycle (step_last)
    );

    // Advance to the next step at the end of each timed interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= ST_RST_HOLD;
        else if (step_last)
            step_q <= init_step_e'(step_q + 4'd1);
    end

    // Drive the command strobes and the done flag from the decoded step.
    assign mem_cs_n  = cmd.cs_n;
    assign mem_ras_n = cmd.ras_n;
    assign mem_cas_n = cmd.cas_n;
    assign mem_we_n  = cmd.we_n;
    assign mem_odt   = 1'b0;
    assign init_done = ready;

    // R2: clock enable is never high while the memory is held in reset.
    a_r2_cke_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_reset_n |-> !mem_cke);
    // R1: once released, the memory reset stays released.
    a_r1_reset_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_reset_n |=> mem_reset_n);
    // R2: once raised, clock enable stays high.
    a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cke |=> mem_cke);
    // R6: each command lasts one cycle and is followed by a NOOP.
    a_r6_cmd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n) |=> (mem_we_n && !mem_cs_n && mem_ras_n && mem_cas_n));
    // R10: done is sticky and implies NOOP with CKE high.
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && mem_cke && mem_we_n && mem_ras_n));

endmodule

// File: tb/ddr3_init_seq_tb.sv
module ddr3_init_seq_tb_top;

    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;
    localparam int RSTH = 20, CKEH = 30, XPR = 3, DLLK = 5, ZQI = 6, MRD = 4, MOD = 7;
    localparam logic [13:0] MR0V = 14'h0421;   // bit 8 deliberately clear
    localparam logic [13:0] MR1V = 14'h0046;
    localparam logic [13:0] MR2V = 14'h0018;
    localparam logic [13:0] MR3V = 14'h0004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_reset_n, mem_cke, mem_odt, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
    logic [BA_W-1:0]   mem_ba;
    logic [ADDR_W-1:0] mem_addr;

    always #4 clk = ~clk;   // 125 MHz

    ddr3_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .RST_HOLD_CYC(RSTH), .CKE_HOLD_CYC(CKEH),
        .T_XPR(XPR), .T_DLLK(DLLK), .T_ZQINIT(ZQI), .T_MRD(MRD), .T_MOD(MOD),
        .MR0_VAL(MR0V), .MR1_VAL(MR1V), .MR2_VAL(MR2V), .MR3_VAL(MR3V)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_reset_n(mem_reset_n), .mem_cke(mem_cke),
        .mem_odt(mem_odt), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
        .mem_addr(mem_addr), .init_done(init_done)
    );

    typedef struct {
        int          len;
        bit          rn;
        bit          cke;
        bit [3:0]    cmd;
        int          ba;
        int          addr;
        bit          done;
        string       tag;
    } phase_t;

    phase_t q[$];
    phase_t cur;
    int     rem;
    bit     model_live = 1'b0;
    int     checks = 0;
    int     failures = 0;
    int     cycles = 0;
    bit     done_seen = 1'b0;
    bit     finished = 1'b0;

    function automatic phase_t mk(int len, bit rn, bit cke, bit [3:0] cmd, int ba, int addr,
                                  bit done, string tag);
        phase_t p;
        p.len = len; p.rn = rn; p.cke = cke; p.cmd = cmd; p.ba = ba; p.addr = addr;
        p.done = done; p.tag = tag;
        return p;
    endfunction

    // Expected timeline, built from the requirements (NOOP = 0111, MRS = 0000, ZQCL = 0110).
    task automatic rebuild();
        q.delete();
        q.push_back(mk(RSTH, 0, 0, 4'b0111, 0, 0, 0, "R1"));
        q.push_back(mk(CKEH, 1, 0, 4'b0111, 0, 0, 0, "R2"));
        q.push_back(mk(XPR + DLLK + ZQI, 1, 1, 4'b0111, 0, 0, 0, "R5"));
        q.push_back(mk(1, 1, 1, 4'b0000, 2, int'(MR2V), 0, "R6"));
        q.push_back(mk(MRD, 1, 1, 4'b0111, 0, 0, 0, "R7"));
        q.push_back(mk(1, 1, 1, 4'b0000, 3, int'(MR3V), 0, "R6"));
        q.push_back(mk(MRD, 1, 1, 4'b0111, 0, 0, 0, "R7"));
        q.push_back(mk(1, 1, 1, 4'b0000, 1, int'(MR1V), 0, "R6"));
        q.push_back(mk(MOD, 1, 1, 4'b0111, 0, 0, 0, "R7"));
        q.push_back(mk(1, 1, 1, 4'b0000, 0, int'(MR0V) | 256, 0, "R8"));
        q.push_back(mk(MOD, 1, 1, 4'b0111, 0, 0, 0, "R7"));
        q.push_back(mk(1, 1, 1, 4'b0110, 0, 1024, 0, "R9"));
        q.push_back(mk(ZQI, 1, 1, 4'b0111, 0, 0, 0, "R9"));
        q.push_back(mk(1000000, 1, 1, 4'b0111, 0, 0, 1, "R10"));
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Reference model: advance the expected phase on each clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            rebuild();
            cur = q.pop_front();
            rem = cur.len;
            model_live = 1'b1;
        end else if (model_live) begin
            if (rem > 1) rem--;
            else if (q.size() > 0) begin
                cur = q.pop_front();
                rem = cur.len;
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (model_live && !finished) begin
            check(mem_reset_n == cur.rn, "R1", "mem_reset_n", mem_reset_n, cur.rn);
            check(mem_cke == cur.cke, "R2", "mem_cke", mem_cke, cur.cke);
            check(mem_odt == 1'b0, "R3", "mem_odt", mem_odt, 0);
            check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == cur.cmd,
                  (cur.cmd == 4'b0111 && cur.tag != "R5" && cur.tag != "R7") ? "R4" : cur.tag,
                  "cmd", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, cur.cmd);
            check(int'(mem_ba) == cur.ba, cur.tag, "mem_ba", mem_ba, cur.ba);
            check(int'(mem_addr) == cur.addr, cur.tag, "mem_addr", mem_addr, cur.addr);
            check(init_done == cur.done, "R10", "init_done", init_done, cur.done);
            if (init_done) done_seen = 1'b1;
        end
    end

    // Stimulus: reset, partial run, mid-sequence reset (R11), full run.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (RSTH + CKEH + 5) @(negedge clk);
        // R11: reset mid-pad; model restarts from the reset-hold phase.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        done_seen = 1'b0;
        repeat (130) @(negedge clk);
        check(done_seen, "R11", "done reached after restart", done_seen, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule